// File: doc/BRIEF.md
# Multi-Bus Fixed-Priority Memory Access Arbiter

This block sits between a processor with separate program and data buses and one shared memory or peripheral slave. The processor presents up to five kinds of access. The program bus carries instruction fetches, program reads and program writes. A dedicated read bus carries data reads. A dedicated write bus carries data writes. When more than one of these targets the slave in the same cycle, the arbiter passes exactly one of them to the slave port, chosen by a fixed rank. Every other requester sees its ready output low and waits.

The grant is purely combinational. It depends only on the requests present in the current cycle and not on any earlier grant. A single read or write moves a full 32-bit word, so a lone request finishes in the cycle it is raised. Read data comes back from the slave one cycle after a read is granted. The arbiter steers it only to the bus that owned that read.

Two pairs of access kinds cannot legally be raised together: a data write with a program write, and a program read with an instruction fetch. If either pair appears, a sticky error flag is set. Arbitration still follows the fixed rank.

Top module: `hbus_arbiter`

## Requirements
- R1: In any cycle at most one access kind is granted, and if any request is raised exactly one is granted and `slv_en` is high; with no request `slv_en` is low.
- R2: The grant rank from highest to lowest is data write, program write, data read, program read, instruction fetch; the highest raised kind wins.
- R3: A request raised alone is granted in the same cycle: its ready output is high in that cycle and the slave port carries its access.
- R4: For the granted kind, `slv_addr` is the data bus address for data accesses and the 22-bit program address zero-extended to 32 bits for program accesses. `slv_we` is high exactly for data writes and program writes. `slv_wdata` is the write data of the granted writer and zero otherwise.
- R5: A source whose request loses arbitration has its ready output low in that cycle. `pb_ready` is high when any program bus kind is granted, `dr_ready` when the data read is granted, and `dw_ready` when the data write is granted.
- R6: The cycle after a data read is granted, `dr_rvalid` is high and `dr_rdata` equals `slv_rdata`. The cycle after a program read or a fetch is granted, `pb_rvalid` is high and `pb_rdata` equals `slv_rdata`. A bus that does not own the returning read has its rvalid low and its rdata zero.
- R7: If a data write and a program write are raised together, or a program read and a fetch are raised together, `proto_err` goes high on the next clock edge. It stays high until reset, and the grant in that cycle still follows R2.
- R8: After reset, `proto_err`, `pb_rvalid` and `dr_rvalid` are low.
- R9: The grant carries no history: the same request pattern always yields the same grant, whatever was granted before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_fetch_req | input | 1 | Instruction fetch request on the program bus |
| pb_read_req | input | 1 | Program read request |
| pb_write_req | input | 1 | Program write request |
| pb_addr | input | 22 | Program bus address |
| pb_wdata | input | 32 | Program write data |
| pb_ready | output | 1 | A program bus access is granted this cycle |
| pb_rvalid | output | 1 | Read data for the program bus is present |
| pb_rdata | output | 32 | Read data returned to the program bus |
| dr_req | input | 1 | Data read request |
| dr_addr | input | 32 | Data read address |
| dr_ready | output | 1 | Data read granted this cycle |
| dr_rvalid | output | 1 | Read data for the data read bus is present |
| dr_rdata | output | 32 | Read data returned to the data read bus |
| dw_req | input | 1 | Data write request |
| dw_addr | input | 32 | Data write address |
| dw_wdata | input | 32 | Data write data |
| dw_ready | output | 1 | Data write granted this cycle |
| slv_en | output | 1 | Slave access strobe |
| slv_we | output | 1 | Slave write enable |
| slv_addr | output | 32 | Slave address |
| slv_wdata | output | 32 | Slave write data |
| slv_rdata | input | 32 | Slave read data, valid the cycle after a read |
| proto_err | output | 1 | Sticky flag for an illegal request pair |

## Verification
The properties assume that request inputs are at known levels from the first clock edge after reset. They also assume the slave presents read data in the cycle right after the read strobe. They do not assume that the forbidden pairs stay apart, so the error flag can be checked against them. The bench changes every input only on the falling clock edge. It covers all legal request patterns before it applies any illegal pair, so the flag can be shown to stay low first. It then applies the illegal pairs and resets again before the directed stall sequence.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   // access kinds; the index is the priority rank (0 is highest)
   localparam int NKIND = 5;
   localparam int K_DWR = 0;
   localparam int K_PWR = 1;
   localparam int K_DRD = 2;
   localparam int K_PRD = 3;
   localparam int K_FET = 4;

   typedef logic [NKIND-1:0] kind_vec_t;
endpackage

// File: rtl/hbus_prio_sel.sv
module hbus_prio_sel #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N:0] blk;

   assign blk[0] = 1'b0;
   generate
      for (genvar i = 0; i < N; i++) begin : g_rank
         assign gnt[i]   = req[i] & ~blk[i];
         assign blk[i+1] = blk[i] | req[i];
      end
   endgenerate

   assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_when_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ($countones(gnt) == 1));
   assert_grant_only_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt & ~req) == '0));
endmodule

// File: rtl/hbus_addr_mux.sv
module hbus_addr_mux
   import hbus_pkg::*;
#(
   parameter int PA_W = 22,
   parameter int SA_W = 32,
   parameter int DW   = 32
) (
   input  kind_vec_t       gnt,
   input  logic [PA_W-1:0] pb_addr,
   input  logic [DW-1:0]   pb_wdata,
   input  logic [SA_W-1:0] dr_addr,
   input  logic [SA_W-1:0] dw_addr,
   input  logic [DW-1:0]   dw_wdata,
   output logic            slv_en,
   output logic            slv_we,
   output logic [SA_W-1:0] slv_addr,
   output logic [DW-1:0]   slv_wdata
);
   logic [SA_W-1:0] pb_ext;

   always_comb begin
      pb_ext             = '0;
      pb_ext[PA_W-1:0]   = pb_addr;
   end

   always_comb begin
      slv_en    = |gnt;
      slv_we    = gnt[K_DWR] | gnt[K_PWR];
      slv_addr  = '0;
      slv_wdata = '0;
      if (gnt[K_DWR]) begin
         slv_addr  = dw_addr;
         slv_wdata = dw_wdata;
      end else if (gnt[K_PWR]) begin
         slv_addr  = pb_ext;
         slv_wdata = pb_wdata;
      end else if (gnt[K_DRD]) begin
         slv_addr  = dr_addr;
      end else if (gnt[K_PRD] | gnt[K_FET]) begin
         slv_addr  = pb_ext;
      end
   end
endmodule

// File: rtl/hbus_rd_route.sv
module hbus_rd_route
   import hbus_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  kind_vec_t     gnt,
   input  logic [DW-1:0] slv_rdata,
   output logic          pb_rvalid,
   output logic [DW-1:0] pb_rdata,
   output logic          dr_rvalid,
   output logic [DW-1:0] dr_rdata
);
   logic own_pb_q;
   logic own_dr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_pb_q <= 1'b0;
         own_dr_q <= 1'b0;
      end else begin
         own_pb_q <= gnt[K_PRD] | gnt[K_FET];
         own_dr_q <= gnt[K_DRD];
      end
   end

   assign pb_rvalid = own_pb_q;
   assign dr_rvalid = own_dr_q;

   generate
      if (ZERO_IDLE) begin : g_gated
         assign pb_rdata = own_pb_q ? slv_rdata : '0;
         assign dr_rdata = own_dr_q ? slv_rdata : '0;
      end else begin : g_open
         assign pb_rdata = slv_rdata;
         assign dr_rdata = slv_rdata;
      end
   endgenerate

   assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pb_rvalid && dr_rvalid));
   assert_dr_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[K_DRD] |=> dr_rvalid);
   assert_pb_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[K_PRD] || gnt[K_FET]) |=> pb_rvalid);
   assert_no_write_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[K_DWR] || gnt[K_PWR]) |=> !(pb_rvalid || dr_rvalid));
endmodule

// File: rtl/hbus_proto_mon.sv
module hbus_proto_mon
   import hbus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  kind_vec_t req,
   output logic      proto_err
);
   logic bad_pair;
   logic err_q;

   assign bad_pair = (req[K_DWR] & req[K_PWR]) | (req[K_PRD] & req[K_FET]);

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | bad_pair;
   end

   assign proto_err = err_q;

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
   assert_err_on_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((req[K_DWR] && req[K_PWR]) || (req[K_PRD] && req[K_FET])) |=> proto_err);
endmodule

// File: rtl/hbus_arbiter.sv
module hbus_arbiter
   import hbus_pkg::*;
#(
   parameter int PA_W      = 22,
   parameter int SA_W      = 32,
   parameter int DW        = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pb_fetch_req,
   input  logic            pb_read_req,
   input  logic            pb_write_req,
   input  logic [PA_W-1:0] pb_addr,
   input  logic [DW-1:0]   pb_wdata,
   output logic            pb_ready,
   output logic            pb_rvalid,
   output logic [DW-1:0]   pb_rdata,
   input  logic            dr_req,
   input  logic [SA_W-1:0] dr_addr,
   output logic            dr_ready,
   output logic            dr_rvalid,
   output logic [DW-1:0]   dr_rdata,
   input  logic            dw_req,
   input  logic [SA_W-1:0] dw_addr,
   input  logic [DW-1:0]   dw_wdata,
   output logic            dw_ready,
   output logic            slv_en,
   output logic            slv_we,
   output logic [SA_W-1:0] slv_addr,
   output logic [DW-1:0]   slv_wdata,
   input  logic [DW-1:0]   slv_rdata,
   output logic            proto_err
);
   generate
      if (PA_W > SA_W) begin : g_bad_width
         $error("program address wider than slave address");
      end
      if (PA_W < 1 || DW < 1) begin : g_bad_size
         $error("widths must be positive");
      end
   endgenerate

   kind_vec_t req;
   kind_vec_t gnt;

   always_comb begin
      req        = '0;
      req[K_DWR] = dw_req;
      req[K_PWR] = pb_write_req;
      req[K_DRD] = dr_req;
      req[K_PRD] = pb_read_req;
      req[K_FET] = pb_fetch_req;
   end

   hbus_prio_sel #(.N(NKIND)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .gnt   (gnt)
   );

   hbus_addr_mux #(.PA_W(PA_W), .SA_W(SA_W), .DW(DW)) u_mux (
      .gnt       (gnt),
      .pb_addr   (pb_addr),
      .pb_wdata  (pb_wdata),
      .dr_addr   (dr_addr),
      .dw_addr   (dw_addr),
      .dw_wdata  (dw_wdata),
      .slv_en    (slv_en),
      .slv_we    (slv_we),
      .slv_addr  (slv_addr),
      .slv_wdata (slv_wdata)
   );

   hbus_rd_route #(.DW(DW), .ZERO_IDLE(ZERO_IDLE)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt       (gnt),
      .slv_rdata (slv_rdata),
      .pb_rvalid (pb_rvalid),
      .pb_rdata  (pb_rdata),
      .dr_rvalid (dr_rvalid),
      .dr_rdata  (dr_rdata)
   );

   hbus_proto_mon u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .proto_err (proto_err)
   );

   assign pb_ready = gnt[K_PWR] | gnt[K_PRD] | gnt[K_FET];
   assign dr_ready = gnt[K_DRD];
   assign dw_ready = gnt[K_DWR];

   assert_dw_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dw_req |-> (dw_ready && !dr_ready && slv_we));
   assert_ready_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pb_ready, dr_ready, dw_ready}));
   assert_en_matches_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      slv_en == (dw_req || dr_req || pb_fetch_req || pb_read_req || pb_write_req));
   assert_rst_clear_R8: assert property (@(posedge clk)
      $past(!rst_n) |-> !(proto_err || pb_rvalid || dr_rvalid));
endmodule

// File: tb/sim_hbus_arbiter.sv
`timescale 1ns/1ps
module sim_hbus_arbiter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        pb_fetch_req, pb_read_req, pb_write_req;
   logic [21:0] pb_addr;
   logic [31:0] pb_wdata;
   logic        pb_ready, pb_rvalid;
   logic [31:0] pb_rdata;
   logic        dr_req;
   logic [31:0] dr_addr;
   logic        dr_ready, dr_rvalid;
   logic [31:0] dr_rdata;
   logic        dw_req;
   logic [31:0] dw_addr, dw_wdata;
   logic        dw_ready;
   logic        slv_en, slv_we;
   logic [31:0] slv_addr, slv_wdata, slv_rdata;
   logic        proto_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   hbus_arbiter u0 (
      .clk(clk), .rst_n(rst_n),
      .pb_fetch_req(pb_fetch_req), .pb_read_req(pb_read_req), .pb_write_req(pb_write_req),
      .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_ready(pb_ready),
      .pb_rvalid(pb_rvalid), .pb_rdata(pb_rdata),
      .dr_req(dr_req), .dr_addr(dr_addr), .dr_ready(dr_ready),
      .dr_rvalid(dr_rvalid), .dr_rdata(dr_rdata),
      .dw_req(dw_req), .dw_addr(dw_addr), .dw_wdata(dw_wdata), .dw_ready(dw_ready),
      .slv_en(slv_en), .slv_we(slv_we), .slv_addr(slv_addr), .slv_wdata(slv_wdata),
      .slv_rdata(slv_rdata), .proto_err(proto_err)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit illegal(input logic [4:0] m);
      return (m[0] && m[1]) || (m[3] && m[4]);
   endfunction

   // bit order of m: 0 data write, 1 program write, 2 data read, 3 program read, 4 fetch
   task automatic drive(input logic [4:0] m);
      dw_req       = m[0];
      pb_write_req = m[1];
      dr_req       = m[2];
      pb_read_req  = m[3];
      pb_fetch_req = m[4];
      dw_addr      = 32'hD000_0000 | 32'(m);
      dr_addr      = 32'hA000_0000 | 32'(m);
      pb_addr      = 22'h3F0000 | 22'(m);
      dw_wdata     = 32'h5555_0000 | 32'(m);
      pb_wdata     = 32'h7777_0000 | 32'(m);
   endtask

   task automatic step(input logic [4:0] m);
      int k;
      logic [31:0] e_addr, e_wd, pat;
      k = 5;
      for (int i = 4; i >= 0; i--) if (m[i]) k = i;
      @(negedge clk);
      drive(m);
      #1;
      e_addr = 32'h0; e_wd = 32'h0;
      case (k)
         0: begin e_addr = dw_addr; e_wd = dw_wdata; end
         1: begin e_addr = {10'h0, pb_addr}; e_wd = pb_wdata; end
         2: e_addr = dr_addr;
         3, 4: e_addr = {10'h0, pb_addr};
         default: ;
      endcase
      check($sformatf("R1 slv_en m=%0h", m), 64'(slv_en), 64'(m != 0));
      check($sformatf("R2/R9 slv_addr m=%0h", m), 64'(slv_addr), 64'(e_addr));
      check($sformatf("R4 slv_we m=%0h", m), 64'(slv_we), 64'(k == 0 || k == 1));
      check($sformatf("R4 slv_wdata m=%0h", m), 64'(slv_wdata), 64'(e_wd));
      check($sformatf("R5 readies m=%0h", m), 64'({pb_ready, dr_ready, dw_ready}),
            64'({(k == 1 || k == 3 || k == 4), (k == 2), (k == 0)}));
      if ($countones(m) == 1)
         check($sformatf("R3 lone grant m=%0h", m),
               64'(pb_ready | dr_ready | dw_ready), 64'(1));
      @(negedge clk);
      drive(5'b0);
      pat = 32'hC0DE_0000 | 32'(m);
      slv_rdata = pat;
      #1;
      check($sformatf("R6 pb_rvalid m=%0h", m), 64'(pb_rvalid), 64'(k == 3 || k == 4));
      check($sformatf("R6 dr_rvalid m=%0h", m), 64'(dr_rvalid), 64'(k == 2));
      check($sformatf("R6 pb_rdata m=%0h", m), 64'(pb_rdata),
            64'((k == 3 || k == 4) ? pat : 32'h0));
      check($sformatf("R6 dr_rdata m=%0h", m), 64'(dr_rdata), 64'((k == 2) ? pat : 32'h0));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      drive(5'b0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R8 proto_err after reset", 64'(proto_err), 64'(0));
      check("R8 rvalid after reset", 64'({pb_rvalid, dr_rvalid}), 64'(0));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      slv_rdata = 32'h0;
      drive(5'b0);
      do_reset();

      // all legal patterns
      for (int m = 0; m < 32; m++)
         if (!illegal(5'(m))) step(5'(m));
      check("R7 no error on legal patterns", 64'(proto_err), 64'(0));

      // history independence: same pattern after different predecessors
      step(5'b00001);
      step(5'b10100);
      step(5'b11100);
      step(5'b10100);

      // illegal pairs: grant still by rank, flag set and held
      for (int m = 0; m < 32; m++)
         if (illegal(5'(m))) begin
            step(5'(m));
            check($sformatf("R7 sticky error m=%0h", m), 64'(proto_err), 64'(1));
         end
      step(5'b00000);
      check("R7 error held after idle", 64'(proto_err), 64'(1));
      do_reset();

      // stalled sources hold their requests until granted
      @(negedge clk);
      drive(5'b10101);
      #1;
      check("R5 stall 1 dw wins", 64'({pb_ready, dr_ready, dw_ready}), 64'(3'b001));
      @(negedge clk);
      drive(5'b10100);
      #1;
      check("R5 stall 2 dr wins", 64'({pb_ready, dr_ready, dw_ready}), 64'(3'b010));
      check("R4 stall 2 addr", 64'(slv_addr), 64'(32'hA000_0014));
      @(negedge clk);
      drive(5'b10000);
      #1;
      check("R5 stall 3 fetch wins", 64'({pb_ready, dr_ready, dw_ready}), 64'(3'b100));
      check("R4 stall 3 addr", 64'(slv_addr), 64'(32'h003F_0010));
      @(negedge clk);
      drive(5'b0);
      slv_rdata = 32'hBEEF_0001;
      #1;
      check("R6 fetch data after stall", 64'(pb_rdata), 64'(32'hBEEF_0001));
      check("R7 no error in stall run", 64'(proto_err), 64'(0));

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule